// File: doc/BRIEF.md
# Serial Port FIFO Interrupt and DMA Request Generator

This block sits beside the transmit and receive FIFOs of a serial port. It turns their event strobes into sticky status flags and drives the requests that the rest of the chip acts on. Those requests are four separate interrupt lines, one priority-encoded interrupt code, and one DMA request line for each direction.

Five events can each set a flag:
- the transmit FIFO has fallen below its threshold;
- the receive FIFO has reached its threshold;
- received data is waiting after the line went idle;
- a receive error occurred;
- a break was detected.

Three control bits gate the interrupts:
- a transmit interrupt enable;
- a receive interrupt enable;
- a receive-error enable. This enable can pass the error and break interrupts on its own while the receive-data interrupt stays blocked.

The DMA requests follow the flags directly and ignore every enable. Software can therefore mask the interrupts and let a DMA engine move the data.

Software clears a flag in two steps. It first reads the status register. It then writes 0 to each flag it saw as 1. A zero written without that prior read has no effect, and so does any written 1. This stops software from losing an event that arrived after it looked at the register.

Top module: `uirq_requester`

## Requirements
- R1: A one-cycle strobe on any event input sets its flag. The flag appears in the status register (select 1) at these bit positions: 0 transmit-low, 1 receive-threshold, 2 data-ready, 3 receive-error, 4 break. The flag holds until it is cleared.
- R2: Writing 0 to a status bit clears that flag only if a status read with `rd_en` high saw the bit as 1 beforehand. Writing 0 with no such read leaves the flag set. Writing 1 never changes a flag.
- R3: If an accepted clear and a set strobe hit the same flag in the same cycle, the flag stays set.
- R4: `irq_txe` is high only while the transmit-low flag is set and the transmit enable (control bit 0) is 1.
- R5: With the receive enable (control bit 1) at 1, the interrupts follow their flags. `irq_rxd` follows the receive-threshold flag OR the data-ready flag. `irq_err` follows the error flag and `irq_brk` follows the break flag.
- R6: With the receive enable at 0 and the receive-error enable (control bit 2) at 1, `irq_err` and `irq_brk` still follow their flags, and `irq_rxd` stays low.
- R7: With both receive-side enables at 0, `irq_rxd`, `irq_err` and `irq_brk` all stay low.
- R8: `dma_tx` follows the transmit-low flag whatever the enables are.
- R9: `dma_rx` follows the receive-threshold flag OR the data-ready flag whatever the enables are.
- R10: `irq_code` names the highest-priority asserted interrupt line. The codes are 1 for error, 2 for receive data, 3 for break and 4 for transmit, in that priority order. The code is 0 when no line is asserted.
- R11: All request outputs are registered. They change one clock after the flag or enable change that causes them, which is two clocks after an event strobe.
- R12: Reset clears all flags, all enables and all outputs. The control register reads back the enable bits written at select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_tx_low | input | 1 | Strobe: transmit FIFO below threshold |
| ev_rx_thr | input | 1 | Strobe: receive FIFO at threshold |
| ev_rx_ready | input | 1 | Strobe: receive data ready after idle |
| ev_rx_err | input | 1 | Strobe: receive error |
| ev_break | input | 1 | Strobe: break detected |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 5 | Write data |
| rd_en | input | 1 | Status read strobe; a read at select 1 arms the clears |
| rd_sel | input | 1 | Read source: 0 control, 1 status |
| rd_data | output | 5 | Read data (combinational) |
| irq_txe | output | 1 | Transmit-low interrupt |
| irq_rxd | output | 1 | Receive-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |
| irq_brk | output | 1 | Break interrupt |
| irq_code | output | 3 | Highest-priority pending interrupt code |
| dma_tx | output | 1 | Transmit DMA request |
| dma_rx | output | 1 | Receive DMA request |

## Verification
The bench builds the block with its default two-stage reset synchronizer and the fixed five-bit register width. With these values every status bit and every control bit can be reached directly.

A vector table covers the priority and gating cases. A computed sweep then runs all eight enable settings against all 32 flag patterns, so each mix of ties in the priority encoder is exercised. Directed tests cover:
- the read-before-clear rule and the set-wins rule;
- the exact latency of the registered outputs;
- a reset asserted mid-run.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int NUM_EN    = 3;
  localparam int REG_W     = NUM_FLAGS;
  localparam int CODE_W    = 3;

  localparam int F_TXE = 0;
  localparam int F_RXF = 1;
  localparam int F_RDY = 2;
  localparam int F_ERR = 3;
  localparam int F_BRK = 4;

  localparam int E_TX  = 0;
  localparam int E_RX  = 1;
  localparam int E_ERR = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE = 3'd0,
    CODE_ERR  = 3'd1,
    CODE_RXD  = 3'd2,
    CODE_BRK  = 3'd3,
    CODE_TXE  = 3'd4
  } irq_code_e;
endpackage

// File: rtl/uirq_rst_sync.sv
module uirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank
  import uirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_stb_i,
  input  logic                 rd_stat_i,
  input  logic                 wr_stat_i,
  input  logic [NUM_FLAGS-1:0] wr_bits_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic [NUM_FLAGS-1:0] flag_q, flag_d, flag_ce;
  logic [NUM_FLAGS-1:0] arm_q, arm_d, arm_ce;
  logic [NUM_FLAGS-1:0] clr_ok;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    // next-state: clear only if armed by a read that saw 1; set wins
    always_comb begin
      clr_ok[i]  = wr_stat_i && !wr_bits_i[i] && arm_q[i];
      flag_ce[i] = set_stb_i[i] || clr_ok[i];
      flag_d[i]  = set_stb_i[i] ? 1'b1 : 1'b0;
      arm_ce[i]  = clr_ok[i] || rd_stat_i;
      if (clr_ok[i]) arm_d[i] = 1'b0;
      else           arm_d[i] = flag_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        if (flag_ce[i]) flag_q[i] <= flag_d[i];
        if (arm_ce[i])  arm_q[i]  <= arm_d[i];
      end
    end

    // R1 / R3: a strobe always leaves the flag set next cycle
    p_set_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb_i[i] |=> flag_q[i]);

    // R2: an unarmed zero write cannot drop a set flag
    p_clear_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !arm_q[i]) |=> flag_q[i]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/uirq_ctrl_reg.sv
module uirq_ctrl_reg
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic [NUM_EN-1:0] wr_bits_i,
  output logic [NUM_EN-1:0] en_o
);
  logic [NUM_EN-1:0] en_q, en_d;
  logic              en_ce;

  always_comb begin
    en_ce = wr_ctrl_i;
    en_d  = wr_bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  // R12: enables change only through a control write
  p_en_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl_i |=> $stable(en_o));
endmodule

// File: rtl/uirq_req_gen.sv
module uirq_req_gen
  import uirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_EN-1:0]    en_i,
  output logic                 irq_txe_o,
  output logic                 irq_rxd_o,
  output logic                 irq_err_o,
  output logic                 irq_brk_o,
  output logic [CODE_W-1:0]    irq_code_o,
  output logic                 dma_tx_o,
  output logic                 dma_rx_o
);
  localparam int OUT_W = 4 + CODE_W + 2;

  logic        txe_d, rxd_d, err_d, brk_d, dtx_d, drx_d;
  logic        rx_side_en;
  irq_code_e   code_d;
  logic [OUT_W-1:0] out_d, out_q;
  logic        out_ce;

  always_comb begin
    rx_side_en = en_i[E_RX] || en_i[E_ERR];
    txe_d = flags_i[F_TXE] && en_i[E_TX];
    rxd_d = (flags_i[F_RXF] || flags_i[F_RDY]) && en_i[E_RX];
    err_d = flags_i[F_ERR] && rx_side_en;
    brk_d = flags_i[F_BRK] && rx_side_en;
    dtx_d = flags_i[F_TXE];
    drx_d = flags_i[F_RXF] || flags_i[F_RDY];

    if      (err_d) code_d = CODE_ERR;
    else if (rxd_d) code_d = CODE_RXD;
    else if (brk_d) code_d = CODE_BRK;
    else if (txe_d) code_d = CODE_TXE;
    else            code_d = CODE_NONE;

    out_d  = {txe_d, rxd_d, err_d, brk_d, code_d, dtx_d, drx_d};
    out_ce = (out_d != out_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_ce) out_q <= out_d;
  end

  assign {irq_txe_o, irq_rxd_o, irq_err_o, irq_brk_o, irq_code_o, dma_tx_o, dma_rx_o} = out_q;

  // R4: transmit interrupt masked by its enable
  p_txe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i[E_TX] |=> !irq_txe_o);

  // R5: receive enable passes a set error flag
  p_err_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i[E_RX] && flags_i[F_ERR]) |=> irq_err_o);

  // R6: receive-data interrupt needs the receive enable
  p_rxd_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i[E_RX] |=> !irq_rxd_o);

  // R7: both receive-side enables off silences the receive side
  p_rx_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i[E_RX] && !en_i[E_ERR]) |=> !(irq_rxd_o || irq_err_o || irq_brk_o));

  // R8: transmit DMA request from flag only
  p_dma_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_i[F_TXE] |=> dma_tx_o);

  // R9: receive DMA request from either receive flag
  p_dma_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[F_RXF] || flags_i[F_RDY]) |=> dma_rx_o);

  // R10: code 0 exactly when no interrupt line is up
  p_code_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code_o == CODE_NONE) == !(irq_txe_o || irq_rxd_o || irq_err_o || irq_brk_o));

  // R10: error outranks every other source
  p_code_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o |-> (irq_code_o == CODE_ERR));
endmodule

// File: rtl/uirq_requester.sv
module uirq_requester
  import uirq_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_low,
  input  logic              ev_rx_thr,
  input  logic              ev_rx_ready,
  input  logic              ev_rx_err,
  input  logic              ev_break,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_txe,
  output logic              irq_rxd,
  output logic              irq_err,
  output logic              irq_brk,
  output logic [CODE_W-1:0] irq_code,
  output logic              dma_tx,
  output logic              dma_rx
);
  logic                 rst_ns;
  logic [NUM_FLAGS-1:0] set_stb;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_EN-1:0]    en;
  logic                 wr_stat, wr_ctrl, rd_stat;

  uirq_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_ns)
  );

  always_comb begin
    set_stb        = '0;
    set_stb[F_TXE] = ev_tx_low;
    set_stb[F_RXF] = ev_rx_thr;
    set_stb[F_RDY] = ev_rx_ready;
    set_stb[F_ERR] = ev_rx_err;
    set_stb[F_BRK] = ev_break;
    wr_stat = wr_en && wr_sel;
    wr_ctrl = wr_en && !wr_sel;
    rd_stat = rd_en && rd_sel;
    if (rd_sel) rd_data = flags;
    else        rd_data = {{(REG_W-NUM_EN){1'b0}}, en};
  end

  uirq_flag_bank u_flags (
    .clk       (clk),
    .rst_n     (rst_ns),
    .set_stb_i (set_stb),
    .rd_stat_i (rd_stat),
    .wr_stat_i (wr_stat),
    .wr_bits_i (wr_data),
    .flags_o   (flags)
  );

  uirq_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .wr_ctrl_i (wr_ctrl),
    .wr_bits_i (wr_data[NUM_EN-1:0]),
    .en_o      (en)
  );

  uirq_req_gen u_req (
    .clk        (clk),
    .rst_n      (rst_ns),
    .flags_i    (flags),
    .en_i       (en),
    .irq_txe_o  (irq_txe),
    .irq_rxd_o  (irq_rxd),
    .irq_err_o  (irq_err),
    .irq_brk_o  (irq_brk),
    .irq_code_o (irq_code),
    .dma_tx_o   (dma_tx),
    .dma_rx_o   (dma_rx)
  );

  // R12: while reset is held every request output is low
  p_reset_quiet_r12: assert property (@(posedge clk)
    !rst_ns |-> !(irq_txe || irq_rxd || irq_err || irq_brk || dma_tx || dma_rx));
endmodule

// File: tb/uirq_requester_bench.sv
`timescale 1ns/1ps
module uirq_requester_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_tx_low, ev_rx_thr, ev_rx_ready, ev_rx_err, ev_break;
  logic       wr_en, wr_sel, rd_en, rd_sel;
  logic [4:0] wr_data, rd_data;
  logic       irq_txe, irq_rxd, irq_err, irq_brk, dma_tx, dma_rx;
  logic [2:0] irq_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uirq_requester u_uirq_requester (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_low(ev_tx_low), .ev_rx_thr(ev_rx_thr), .ev_rx_ready(ev_rx_ready),
    .ev_rx_err(ev_rx_err), .ev_break(ev_break),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_txe(irq_txe), .irq_rxd(irq_rxd), .irq_err(irq_err), .irq_brk(irq_brk),
    .irq_code(irq_code), .dma_tx(dma_tx), .dma_rx(dma_rx)
  );

  // vector: {en[2:0]={ree,rie,tie}, flags[4:0]={brk,err,rdy,rxf,txe},
  //          exp[8:0]={irq_txe,irq_rxd,irq_err,irq_brk,code[2:0],dma_tx,dma_rx}}
  localparam int NVEC = 12;
  localparam logic [16:0] VEC [NVEC] = '{
    {3'b001, 5'b00001, 9'b1000_100_10},
    {3'b000, 5'b00001, 9'b0000_000_10},
    {3'b010, 5'b00010, 9'b0100_010_01},
    {3'b010, 5'b00100, 9'b0100_010_01},
    {3'b100, 5'b00110, 9'b0000_000_01},
    {3'b100, 5'b11000, 9'b0011_001_00},
    {3'b000, 5'b11111, 9'b0000_000_11},
    {3'b111, 5'b11111, 9'b1111_001_11},
    {3'b111, 5'b10011, 9'b1101_010_11},
    {3'b011, 5'b10001, 9'b1001_011_10},
    {3'b101, 5'b01001, 9'b1010_001_10},
    {3'b110, 5'b10100, 9'b0101_010_01}
  };

  function automatic logic [8:0] ref_model(input logic [2:0] en, input logic [4:0] fl);
    logic t, r, e, b;
    logic [2:0] c;
    t = fl[0] & en[0];
    r = (fl[1] | fl[2]) & en[1];
    e = fl[3] & (en[1] | en[2]);
    b = fl[4] & (en[1] | en[2]);
    c = e ? 3'd1 : r ? 3'd2 : b ? 3'd3 : t ? 3'd4 : 3'd0;
    return {t, r, e, b, c, fl[0], fl[1] | fl[2]};
  endfunction

  function automatic logic [8:0] outs();
    return {irq_txe, irq_rxd, irq_err, irq_brk, irq_code, dma_tx, dma_rx};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic reg_write(input logic sel, input logic [4:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic stat_read();
    rd_en = 1'b1; rd_sel = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic peek_status(output logic [4:0] v);
    rd_sel = 1'b1; #0.1; v = rd_data;
  endtask

  task automatic drive_ev(input logic [4:0] fl);
    {ev_break, ev_rx_err, ev_rx_ready, ev_rx_thr, ev_tx_low} = fl;
  endtask

  task automatic pulse(input logic [4:0] fl);
    drive_ev(fl); tick(); drive_ev(5'b0);
  endtask

  task automatic clear_all();
    stat_read();
    reg_write(1'b1, 5'b00000);
  endtask

  task automatic apply(input logic [2:0] en, input logic [4:0] fl);
    reg_write(1'b0, {2'b00, en});
    clear_all();
    pulse(fl);
    tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] v;
    wr_en = 0; wr_sel = 0; wr_data = 0; rd_en = 0; rd_sel = 0;
    drive_ev(5'b0);
    do_reset();

    // R12: reset state
    check("R12 outputs after reset", outs(), 9'b0);
    peek_status(v); check("R12 status after reset", {4'b0, v}, 9'b0);
    rd_sel = 1'b0; #0.1; check("R12 control after reset", {4'b0, rd_data}, 9'b0);
    reg_write(1'b0, 5'b00101);
    rd_sel = 1'b0; #0.1; check("R12 control readback", {4'b0, rd_data}, 9'b0_0000_0101);

    // table: R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][16:14], VEC[i][13:9]);
      check("R4/R5/R6/R7/R8/R9/R10 vector", outs(), VEC[i][8:0]);
    end

    // sweep all enables against all flag patterns, reference model
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 32; f++) begin
        apply(3'(e), 5'(f));
        check("R10 sweep", outs(), ref_model(3'(e), 5'(f)));
      end
    end

    // R1: flag visible at its bit position
    reg_write(1'b0, 5'b0); clear_all();
    pulse(5'b01000); tick();
    peek_status(v); check("R1 error flag at bit 3", {4'b0, v}, 9'b0_0000_1000);

    // R2: zero write without prior read has no effect
    reg_write(1'b1, 5'b00000); tick();
    peek_status(v); check("R2 unarmed clear ignored", {4'b0, v}, 9'b0_0000_1000);
    // R2: writing 1 after read has no effect
    stat_read(); reg_write(1'b1, 5'b11111); tick();
    peek_status(v); check("R2 write one ignored", {4'b0, v}, 9'b0_0000_1000);
    // R2: read then zero write clears
    reg_write(1'b1, 5'b00000); tick();
    peek_status(v); check("R2 armed clear", {4'b0, v}, 9'b0);

    // R2: flag set after the read is not cleared by the write
    stat_read(); pulse(5'b10000); reg_write(1'b1, 5'b00000); tick();
    peek_status(v); check("R2 late flag kept", {4'b0, v}, 9'b0_0001_0000);
    clear_all();

    // R3: set wins over an accepted clear
    pulse(5'b00001); stat_read();
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 5'b0; drive_ev(5'b00001);
    tick();
    wr_en = 1'b0; drive_ev(5'b0); tick();
    peek_status(v); check("R3 set wins", {4'b0, v}, 9'b0_0000_0001);
    clear_all(); tick();

    // R11: two-clock latency from strobe to dma_tx
    drive_ev(5'b00001); tick(); drive_ev(5'b0);
    check("R11 dma_tx not yet", {8'b0, dma_tx}, 9'b0);
    tick();
    check("R11 dma_tx after two clocks", {8'b0, dma_tx}, 9'b1);
    // R11: enable write reaches irq_txe one clock later
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 5'b00001; tick(); wr_en = 1'b0;
    check("R11 irq_txe not yet", {8'b0, irq_txe}, 9'b0);
    tick();
    check("R11 irq_txe after one clock", {8'b0, irq_txe}, 9'b1);

    // R12: reset mid-run clears everything
    reg_write(1'b0, 5'b00111); pulse(5'b11111); tick();
    do_reset();
    check("R12 outputs after second reset", outs(), 9'b0);
    peek_status(v); check("R12 flags after second reset", {4'b0, v}, 9'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule